// File: doc/BRIEF.md
# Transfer Address Range Checker

This block sits between the address generation stage of a load/store unit and the memory interface. It checks every computed 32-bit transfer address against a 26-bit physical address space (legal range 0 to 0x3FFFFFF). It forwards the low 26 bits to the bus as a request, or it raises a one-cycle address-exception pulse and withholds the request. The fault is detected inside the block. No external abort input plays a part.

There are two kinds of transfer, and they are treated differently. For a single load or store, each effective address (base plus offset) is checked on its own. For a block (multiple-register) transfer, only the base presented with the first transfer of the instruction is checked. That decision is latched for the rest of the instruction. Later auto-incremented addresses are never checked. When they pass the top of the space, they are truncated and continue from the bottom of the memory map. All outputs are registered and appear one cycle after the transfer strobe.

Top module: `xfer_range_chk`

## Requirements
- R1: After reset, `bus_req` and `addr_exc` are low and `bus_addr` is zero.
- R2: A single transfer (`xfer_multi`=0) whose address is at most 0x3FFFFFF produces, on the next cycle, `bus_req`=1, `addr_exc`=0 and `bus_addr` equal to address bits [25:0]. 0x3FFFFFF itself is legal.
- R3: A single transfer whose address exceeds 0x3FFFFFF (any of bits [31:26] set, e.g. 0x4000000) produces, on the next cycle, `addr_exc`=1 for exactly one cycle with `bus_req`=0.
- R4: A block transfer (`xfer_multi`=1) strobed together with `instr_start`=1 and a base above 0x3FFFFFF produces a one-cycle `addr_exc` with `bus_req`=0.
- R5: After a legal block start, the later block transfers of the same instruction (`instr_start`=0) never raise `addr_exc`. They issue `bus_req` with `bus_addr` equal to address bits [25:0], so 0x4000000 wraps to 0 and 0x4000008 wraps to 8.
- R6: After an illegal block start, the remaining block transfers of that instruction give `bus_req`=0 and `addr_exc`=0.
- R7: Each new block start evaluates its own base afresh. A legal start after an illegal one issues requests normally.
- R8: In a cycle without `xfer_valid`, the next cycle has `bus_req`=0 and `addr_exc`=0, and `bus_addr` keeps its previous value.
- R9: `instr_start` without `xfer_valid` has no effect: it neither raises an exception nor changes the latched block decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| xfer_valid | input | 1 | Per-transfer strobe |
| xfer_multi | input | 1 | 1 = block transfer, 0 = single transfer |
| instr_start | input | 1 | Marks the first transfer of an instruction (qualified by xfer_valid) |
| addr_in | input | 32 | Computed transfer address |
| bus_addr | output | 26 | Registered bus address, bits [25:0] of the transfer address |
| bus_req | output | 1 | Registered memory request |
| addr_exc | output | 1 | Registered one-cycle address-exception pulse |

## Verification
The bench tests single transfers right at the boundary, with 0x3FFFFFF and 0x4000000. A design that compares with the wrong inequality, or looks at too few upper bits, lets a fault through or rejects a legal top word. It runs a block instruction that starts legal and then steps past the top. A design that checks every transfer would fault there, and one that does not truncate would send a wrong bus address instead of 0 or 8. It also starts a block illegally and follows it with a legal start. A design that does not latch the decision, or never clears it, would either issue the abandoned transfers or keep suppressing the next instruction. A bare `instr_start` in an idle cycle checks that the latch is qualified by the transfer strobe.

// File: rtl/xfer_range_chk.sv
module xfer_range_chk #(
  parameter int ADDR_W = 32,
  parameter int BUS_W  = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer_valid,
  input  logic              xfer_multi,
  input  logic              instr_start,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [BUS_W-1:0]  bus_addr,
  output logic              bus_req,
  output logic              addr_exc
);

  localparam int HI_W = ADDR_W - BUS_W;

  logic blk_bad;
  logic out_of_range;
  logic blk_first;
  logic fault;
  logic quiet;

  assign out_of_range = |addr_in[ADDR_W-1:BUS_W];
  assign blk_first    = xfer_valid && xfer_multi && instr_start;
  assign fault        = xfer_valid && (xfer_multi ? (instr_start && out_of_range) : out_of_range);
  assign quiet        = xfer_valid && xfer_multi && !instr_start && blk_bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) blk_bad <= 1'b0;
    else if (blk_first) blk_bad <= out_of_range;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_addr <= '0;
      bus_req  <= 1'b0;
      addr_exc <= 1'b0;
    end else begin
      addr_exc <= fault;
      bus_req  <= xfer_valid && !fault && !quiet;
      if (xfer_valid) bus_addr <= addr_in[BUS_W-1:0];
    end
  end

  // R3
  single_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && !xfer_multi && addr_in[ADDR_W-1:BUS_W] != '0) |=> (addr_exc && !bus_req));

  // R5
  blk_follow_no_exc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && xfer_multi && !instr_start) |=> !addr_exc);

  // R2
  bus_addr_trunc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid |=> (bus_addr == $past(addr_in[BUS_W-1:0])));

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_valid |=> (!bus_req && !addr_exc && $stable(bus_addr)));

  // R3
  exc_excl_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(addr_exc && bus_req));

  // R4
  blk_start_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_first && addr_in[ADDR_W-1:BUS_W] != {HI_W{1'b0}}) |=> (addr_exc && !bus_req));

endmodule

// File: tb/xfer_range_chk_bench.sv
module xfer_range_chk_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        xfer_valid = 1'b0;
  logic        xfer_multi = 1'b0;
  logic        instr_start = 1'b0;
  logic [31:0] addr_in = '0;
  logic [25:0] bus_addr;
  logic        bus_req;
  logic        addr_exc;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  xfer_range_chk u_xfer_range_chk (
    .clk(clk), .rst_n(rst_n), .xfer_valid(xfer_valid), .xfer_multi(xfer_multi),
    .instr_start(instr_start), .addr_in(addr_in),
    .bus_addr(bus_addr), .bus_req(bus_req), .addr_exc(addr_exc)
  );

  task automatic expect_out(string req, logic [25:0] ea, logic er, logic ee);
    checks++;
    if (bus_addr !== ea || bus_req !== er || addr_exc !== ee) begin
      errors++;
      $display("FAIL %s: got addr=%h req=%b exc=%b expected addr=%h req=%b exc=%b",
               req, bus_addr, bus_req, addr_exc, ea, er, ee);
    end
  endtask

  task automatic step(logic v, logic m, logic s, logic [31:0] a);
    @(negedge clk);
    xfer_valid = v; xfer_multi = m; instr_start = s; addr_in = a;
    @(posedge clk); #1;
    xfer_valid = 1'b0; instr_start = 1'b0;
  endtask

  task automatic t_reset();
    #1 expect_out("R1", 26'h0, 1'b0, 1'b0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    expect_out("R1", 26'h0, 1'b0, 1'b0);
  endtask

  task automatic t_single();
    step(1, 0, 0, 32'h0000_1234); expect_out("R2", 26'h1234, 1, 0);
    step(1, 0, 1, 32'h03FF_FFFF); expect_out("R2", 26'h3FFFFFF, 1, 0);
    step(1, 0, 0, 32'h0400_0000); expect_out("R3", 26'h0, 0, 1);
    step(0, 0, 0, 32'h0);         expect_out("R3", 26'h0, 0, 0);
    step(1, 0, 0, 32'h8000_0010); expect_out("R3", 26'h10, 0, 1);
  endtask

  task automatic t_block_wrap();
    step(1, 1, 1, 32'h03FF_FFF8); expect_out("R5", 26'h3FFFFF8, 1, 0);
    step(1, 1, 0, 32'h03FF_FFFC); expect_out("R5", 26'h3FFFFFC, 1, 0);
    step(1, 1, 0, 32'h0400_0000); expect_out("R5", 26'h0, 1, 0);
    step(1, 1, 0, 32'h0400_0008); expect_out("R5", 26'h8, 1, 0);
  endtask

  task automatic t_block_bad();
    step(1, 1, 1, 32'h0400_0100); expect_out("R4", 26'h100, 0, 1);
    step(1, 1, 0, 32'h0400_0104); expect_out("R6", 26'h104, 0, 0);
    step(1, 1, 0, 32'h0000_0108); expect_out("R6", 26'h108, 0, 0);
    step(1, 1, 1, 32'h0000_0200); expect_out("R7", 26'h200, 1, 0);
    step(1, 1, 0, 32'h0000_0204); expect_out("R7", 26'h204, 1, 0);
  endtask

  task automatic t_idle();
    step(0, 1, 0, 32'hFFFF_FFFF); expect_out("R8", 26'h204, 0, 0);
    step(0, 1, 1, 32'hFFFF_FFFF); expect_out("R9", 26'h204, 0, 0);
    step(1, 1, 0, 32'h0000_0300); expect_out("R9", 26'h300, 1, 0);
    step(1, 1, 1, 32'h0400_0000); expect_out("R4", 26'h0, 0, 1);
    step(0, 1, 1, 32'h0000_0000); expect_out("R9", 26'h0, 0, 0);
    step(1, 1, 0, 32'h0000_0040); expect_out("R9", 26'h40, 0, 0);
  endtask

  initial begin
    t_reset();
    t_single();
    t_block_wrap();
    t_block_bad();
    t_idle();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule